// File: doc/BRIEF.md
# Delayed Lockstep Output Comparator

This block watches two copies of a processing core that run the same program with a fixed offset of two clock cycles. The primary core's output bus passes through a register delay. The checker core receives its inputs two cycles late, so its outputs come out two cycles late as well. The delayed primary bus and the checker bus therefore line up in time and are compared on every cycle. Any bit that differs sets a sticky error flag. The flag stays set until an explicit clear is applied. The offset between the cores means that a single disturbance does not hit both copies in the same way.

While lockstep is active, the checker's own outputs toward the system are held at a fixed safe value. A built-in self-test checks the comparator. It drives two equal pattern pairs and then one pair for each bit position that differs in that bit alone. It reports pass only when every equal pair compares equal and every different pair compares different. An error-forcing input inverts bit 0 of the checker side in front of the comparator, so the error path can be exercised on purpose. The same design can be instantiated again to compare two redundant interrupt controllers.

Top module: `lockstep_cmp`

## Requirements
- R1: The primary bus is delayed by exactly two clock edges before comparison. A checker value equal to the primary value driven two cycles earlier raises no error. A checker value equal to the current primary value raises an error when that value differs from the one driven two cycles earlier.
- R2: When comparison is enabled, a difference in any single bit (bit 0 or bit 63) between the aligned buses sets `err_o` at the next clock edge.
- R3: `err_o` stays set until `err_clr_i` is high at a clock edge. If a clear and a new mismatch occur at the same edge, the flag remains set.
- R4: After reset is released, comparison stays disabled for the first two clock edges. The third edge compares.
- R5: With `lockstep_en_i` low, no error is raised and `chk_sys_o` equals `chk_bus_i`. With it high, `chk_sys_o` equals the safe value, which is all zeros by default.
- R6: With comparison enabled and equal aligned buses, `force_err_i` high at an edge sets `err_o`. It does this by inverting bit 0 of the checker side.
- R7: A `st_start_i` pulse while no self-test is running starts a self-test. `st_busy_o` is then high for BUS_W+2 cycles. After that, `st_done_o` is high and `st_pass_o` is 1 on a fault-free comparator.
- R8: While `st_busy_o` is high, a functional mismatch does not set `err_o`.
- R9: Holding `force_err_i` high through a self-test makes that self-test end with `st_done_o`=1 and `st_pass_o`=0.
- R10: During reset, `err_o`, `st_busy_o`, `st_done_o` and `st_pass_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lockstep_en_i | input | 1 | Lockstep active: enables comparison and clamps the checker outputs |
| pri_bus_i | input | BUS_W | Primary core output bus (undelayed) |
| chk_bus_i | input | BUS_W | Checker core output bus (already two cycles late) |
| force_err_i | input | 1 | Inverts bit 0 of the checker side at the comparator |
| err_clr_i | input | 1 | Clears the sticky error flag |
| st_start_i | input | 1 | Starts a self-test |
| chk_sys_o | output | BUS_W | Checker outputs toward the system, clamped during lockstep |
| err_o | output | 1 | Sticky compare error |
| st_busy_o | output | 1 | Self-test running |
| st_done_o | output | 1 | Self-test finished |
| st_pass_o | output | 1 | Result of the last self-test |

## Verification
The hardest condition to reach from the ports is a self-test that fails. A fault-free comparator always passes, so the bench holds error-forcing high for the whole self-test. This corrupts every pattern pair at the comparator input, and the result must be a fail. A second self-test runs while the checker bus deliberately disagrees with the primary bus. This shows that the functional flag stays clear during the test and that it stays clear after the bench realigns the buses. To keep the alignment right, the bench models the two-cycle checker lag itself. It builds each checker value from the primary value it drove two steps earlier.

// File: rtl/lsc_pkg.sv
package lsc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } st_state_e;

   // Alternating bit pattern of the requested width; phase selects the value of bit 0.
   function automatic logic [1023:0] alt_bits(input int unsigned width, input logic phase);
      logic [1023:0] v;
      v = '0;
      for (int unsigned i = 0; i < width; i++) begin
         v[i] = phase ^ i[0];
      end
      return v;
   endfunction

endpackage

// File: rtl/lsc_delay_line.sv
module lsc_delay_line #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic             ready_o
);

   logic [WIDTH-1:0] stg [STAGES];
   logic [STAGES-1:0] fill_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= d_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
      if (STAGES == 1) begin : g_fill_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fill_q <= '0;
            else        fill_q <= 1'b1;
         end
      end else begin : g_fill_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) fill_q <= '0;
            else        fill_q <= {fill_q[STAGES-2:0], 1'b1};
         end
      end
   endgenerate

   assign q_o     = stg[STAGES-1];
   assign ready_o = fill_q[STAGES-1];

   // R4: once the pipeline has filled, it stays filled until reset
   a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |=> ready_o);

endmodule

// File: rtl/lsc_compare.sv
module lsc_compare #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned LANE_W = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             neq_o
);

   localparam int unsigned NLANE = (WIDTH + LANE_W - 1) / LANE_W;
   localparam int unsigned PAD_W = NLANE * LANE_W;

   logic [PAD_W-1:0] diff_pad;
   logic [NLANE-1:0] lane_hit;

   generate
      if (PAD_W == WIDTH) begin : g_exact
         assign diff_pad = a_i ^ b_i;
      end else begin : g_padded
         assign diff_pad = {{(PAD_W-WIDTH){1'b0}}, a_i ^ b_i};
      end
      for (genvar l = 0; l < NLANE; l++) begin : g_lane
         assign lane_hit[l] = |diff_pad[l*LANE_W +: LANE_W];
      end
   endgenerate

   assign neq_o = |lane_hit;

endmodule

// File: rtl/lsc_selftest.sv
module lsc_selftest import lsc_pkg::*; #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             mismatch_i,
   output logic [WIDTH-1:0] pat_a_o,
   output logic [WIDTH-1:0] pat_b_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             pass_o
);

   localparam int unsigned STEPS = WIDTH + 2;
   localparam int unsigned IW    = $clog2(STEPS + 1);
   localparam logic [IW-1:0] LAST = IW'(STEPS - 1);
   localparam logic [WIDTH-1:0] PAT_LO = WIDTH'(alt_bits(WIDTH, 1'b1));
   localparam logic [WIDTH-1:0] PAT_HI = WIDTH'(alt_bits(WIDTH, 1'b0));
   localparam logic [WIDTH-1:0] ONE    = {{(WIDTH-1){1'b0}}, 1'b1};

   st_state_e     state_q;
   logic [IW-1:0] idx_q;
   logic          fail_q, pass_q;
   logic          equal_step, step_bad;

   assign equal_step = (idx_q < IW'(2));
   assign pat_a_o    = (idx_q == IW'(1)) ? PAT_HI : PAT_LO;
   assign pat_b_o    = equal_step ? pat_a_o : (pat_a_o ^ (ONE << (idx_q - IW'(2))));
   assign step_bad   = equal_step ? mismatch_i : !mismatch_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         fail_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_RUN: begin
               if (idx_q == LAST) begin
                  state_q <= ST_DONE;
                  pass_q  <= !(fail_q || step_bad);
               end else begin
                  idx_q  <= idx_q + IW'(1);
                  fail_q <= fail_q || step_bad;
               end
            end
            default: begin
               if (start_i) begin
                  state_q <= ST_RUN;
                  idx_q   <= '0;
                  fail_q  <= 1'b0;
                  pass_q  <= 1'b0;
               end
            end
         endcase
      end
   end

   assign busy_o = (state_q == ST_RUN);
   assign done_o = (state_q == ST_DONE);
   assign pass_o = pass_q;

   // R7: running and finished are never shown together
   a_r7_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({busy_o, done_o}));
   // R7: the end of a run always leaves the done flag up
   a_r7_end_to_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
   // R7: a pass result is only ever presented once done
   a_r7_pass_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      pass_o |-> done_o);

endmodule

// File: rtl/lockstep_cmp.sv
module lockstep_cmp import lsc_pkg::*; #(
   parameter int unsigned BUS_W   = 64,
   parameter int unsigned PRI_DLY = 2,
   parameter int unsigned LANE_W  = 8,
   parameter logic [BUS_W-1:0] CLAMP_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lockstep_en_i,
   input  logic [BUS_W-1:0] pri_bus_i,
   input  logic [BUS_W-1:0] chk_bus_i,
   input  logic             force_err_i,
   input  logic             err_clr_i,
   input  logic             st_start_i,
   output logic [BUS_W-1:0] chk_sys_o,
   output logic             err_o,
   output logic             st_busy_o,
   output logic             st_done_o,
   output logic             st_pass_o
);

   localparam logic [BUS_W-1:0] FORCE_MASK = {{(BUS_W-1){1'b0}}, 1'b1};

   generate
      if (BUS_W < 2)        begin : g_chk_w    $error("BUS_W must be at least 2");     end
      if (BUS_W > 1024)     begin : g_chk_wmax $error("BUS_W must not exceed 1024");   end
      if (PRI_DLY < 1)      begin : g_chk_d    $error("PRI_DLY must be at least 1");   end
      if (LANE_W < 1)       begin : g_chk_l    $error("LANE_W must be at least 1");    end
   endgenerate

   logic [BUS_W-1:0] pri_dly;
   logic             dly_ready;
   logic [BUS_W-1:0] pat_a, pat_b;
   logic [BUS_W-1:0] cmp_a, cmp_b;
   logic             cmp_neq;
   logic             cmp_en;
   logic             err_q;

   lsc_delay_line #(.WIDTH(BUS_W), .STAGES(PRI_DLY)) u_dly (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_i     (pri_bus_i),
      .q_o     (pri_dly),
      .ready_o (dly_ready)
   );

   assign cmp_a = st_busy_o ? pat_a : pri_dly;
   assign cmp_b = (st_busy_o ? pat_b : chk_bus_i) ^ (force_err_i ? FORCE_MASK : '0);

   lsc_compare #(.WIDTH(BUS_W), .LANE_W(LANE_W)) u_cmp (
      .a_i   (cmp_a),
      .b_i   (cmp_b),
      .neq_o (cmp_neq)
   );

   lsc_selftest #(.WIDTH(BUS_W)) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (st_start_i),
      .mismatch_i (cmp_neq),
      .pat_a_o    (pat_a),
      .pat_b_o    (pat_b),
      .busy_o     (st_busy_o),
      .done_o     (st_done_o),
      .pass_o     (st_pass_o)
   );

   assign cmp_en = lockstep_en_i && dly_ready && !st_busy_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (cmp_en && cmp_neq) || (err_q && !err_clr_i);
   end

   assign err_o     = err_q;
   assign chk_sys_o = lockstep_en_i ? CLAMP_VAL : chk_bus_i;

   // R2: an enabled mismatch always lands in the flag
   a_r2_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_en && cmp_neq) |=> err_o);
   // R3: without a clear the flag never drops
   a_r3_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !err_clr_i) |=> err_o);
   // R4: no new error while the delay pipeline is still filling
   a_r4_no_err_unfilled: assert property (@(posedge clk) disable iff (!rst_n)
      (!dly_ready && !err_o) |=> !err_o);
   // R8: a running self-test never raises the functional flag
   a_r8_quiet_in_test: assert property (@(posedge clk) disable iff (!rst_n)
      (st_busy_o && !err_o) |=> !err_o);

endmodule

// File: tb/lockstep_cmp_tb_top.sv
module lockstep_cmp_tb_top;

   localparam int unsigned W = 64;
   localparam logic [W-1:0] ONES = '1;

   typedef struct packed {
      logic [W-1:0] pri;
      logic [W-1:0] mask;
      logic         clr;
      logic         frc;
      logic         exp_err;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t VEC [NVEC] = '{
      '{64'h0123_4567_89AB_CDEF, 64'h0,               1'b0, 1'b0, 1'b0}, // R1 aligned
      '{64'hFEDC_BA98_7654_3210, 64'h0,               1'b0, 1'b0, 1'b0}, // R1 aligned
      '{64'h0F0F_0F0F_F0F0_F0F0, 64'h8000_0000_0000_0000, 1'b0, 1'b0, 1'b1}, // R2 msb
      '{64'h1111_2222_3333_4444, 64'h0,               1'b0, 1'b0, 1'b1}, // R3 sticky
      '{64'h5555_6666_7777_8888, 64'h0,               1'b1, 1'b0, 1'b0}, // R3 clear
      '{64'h9999_AAAA_BBBB_CCCC, 64'h1,               1'b0, 1'b0, 1'b1}, // R2 lsb
      '{64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0010_0000, 1'b1, 1'b0, 1'b1}, // R3 set beats clear
      '{64'h0000_0000_0000_0001, 64'h0,               1'b1, 1'b0, 1'b0}, // R3 clear
      '{64'hA5A5_A5A5_5A5A_5A5A, 64'h0,               1'b0, 1'b1, 1'b1}, // R6 forced
      '{64'h3C3C_3C3C_C3C3_C3C3, 64'h0,               1'b1, 1'b0, 1'b0}  // R3 clear
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lockstep_en = 1'b1;
   logic [W-1:0] pri = '0;
   logic [W-1:0] chk = '0;
   logic         frc = 1'b0;
   logic         clr = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] chk_sys;
   logic         err, busy, done, pass;

   logic [W-1:0] h1 = '0, h2 = '0;
   int n_chk = 0;
   int n_err = 0;

   always #2 clk = ~clk;

   lockstep_cmp dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .lockstep_en_i (lockstep_en),
      .pri_bus_i     (pri),
      .chk_bus_i     (chk),
      .force_err_i   (frc),
      .err_clr_i     (clr),
      .st_start_i    (start),
      .chk_sys_o     (chk_sys),
      .err_o         (err),
      .st_busy_o     (busy),
      .st_done_o     (done),
      .st_pass_o     (pass)
   );

   task automatic check(input logic ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one cycle: checker returns the primary value from two steps ago, xor mask
   task automatic step(input logic [W-1:0] p, input logic [W-1:0] m, input logic c,
                       input logic f, input logic e, input string req);
      pri = p;
      chk = h2 ^ m;
      clr = c;
      frc = f;
      @(posedge clk);
      #1;
      h2 = h1;
      h1 = p;
      check(err == e, req, W'(err), W'(e));
   endtask

   task automatic run_selftest(input logic f, input logic [W-1:0] m, output int busy_cnt);
      logic [W-1:0] c;
      c = 64'h7E57_0000_7E57_0000;
      pri = c; chk = h2; clr = 1'b0; frc = f; start = 1'b1;
      @(posedge clk);
      #1;
      h2 = h1; h1 = c;
      start = 1'b0;
      chk = c ^ m;
      busy_cnt = 0;
      while (busy && busy_cnt < 1000) begin
         busy_cnt++;
         @(posedge clk);
         #1;
         h2 = h1; h1 = c;
      end
      chk = h2;
      frc = 1'b0;
   endtask

   initial begin
      int cnt;
      // R10: reset state
      repeat (3) @(posedge clk);
      #1;
      check({err, busy, done, pass} == 4'b0, "R10", W'({err, busy, done, pass}), '0);
      rst_n = 1'b1;

      // R4: mismatches during the two fill edges are ignored, third edge compares
      step(64'h1, ONES, 1'b0, 1'b0, 1'b0, "R4 fill edge 1");
      step(64'h2, ONES, 1'b0, 1'b0, 1'b0, "R4 fill edge 2");
      step(64'h3, ONES, 1'b0, 1'b0, 1'b1, "R4 third edge");
      step(64'h4, '0,   1'b1, 1'b0, 1'b0, "R4 clear");

      // table walk
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].pri, VEC[i].mask, VEC[i].clr, VEC[i].frc, VEC[i].exp_err, $sformatf("R2/R3/R6 vec %0d", i));
      end

      // R1: checker showing the current primary value is misaligned
      step(64'h0000_0111_0000_0111, h2 ^ 64'h0000_0111_0000_0111, 1'b0, 1'b0, 1'b1, "R1 misaligned");
      step(64'h2, '0, 1'b1, 1'b0, 1'b0, "R1 clear");

      // R5: lockstep off
      lockstep_en = 1'b0;
      step(64'h3, ONES, 1'b0, 1'b0, 1'b0, "R5 no compare off");
      check(chk_sys == chk, "R5 passthrough", chk_sys, chk);
      step(64'h4, '0, 1'b0, 1'b1, 1'b0, "R5 force ignored off");
      lockstep_en = 1'b1;
      #1;
      check(chk_sys == '0, "R5 clamp", chk_sys, '0);
      step(64'h5, '0, 1'b0, 1'b0, 1'b0, "R5 back on");

      // R8 + R7: self-test with corrupted functional checker bus
      run_selftest(1'b0, 64'h00F0, cnt);
      check(cnt == W + 2, "R7 busy length", W'(cnt), W'(W + 2));
      check(done && pass, "R7 pass", W'({done, pass}), W'(2'b11));
      check(!err, "R8 quiet in test", W'(err), '0);
      step(64'h6, '0, 1'b0, 1'b0, 1'b0, "R8 aligned after test");

      // R9: forced error through a self-test
      lockstep_en = 1'b0;
      run_selftest(1'b1, '0, cnt);
      check(done && !pass, "R9 forced fail", W'({done, pass}), W'(2'b10));
      check(!err, "R9 no functional flag", W'(err), '0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule